// File: doc/BRIEF.md
# Dual-plane flash command controller

This block puts a NOR-flash style command interface in front of an on-chip word array. The array is split into two planes, and each plane holds a group of sectors. The host drives chip enable, write enable, output enable, a word address and 16-bit data, as it would on a parallel flash. Writes are decoded as unlock-prefixed command sequences that start a word program, a sector erase, an erase suspend, an erase resume or a sector lock. Program and erase run as timed internal operations, each with its own cycle counter. While they run, the controller reports progress on a ready output and through a status word returned by reads.

Each plane has its own engine. A plane that is idle keeps serving array reads while the other plane programs or erases. An erase can be suspended for an unlimited time. While it is suspended, the other sectors of that plane can be read and programmed. Locked sectors reject program and erase, so their contents are never touched.

Top module: `flashctl_dualplane`

## Requirements
- R1: After reset, `ready` is 1, `rdata` is 0, every array word reads 0xFFFF and no sector is locked.
- R2: Every command begins with two unlock writes: data low byte 0xAA at word address 0x555 truncated to ADDR_W bits (0x55 by default), then 0x55 at 0x2AA truncated (0xAA by default). Only the low data byte is decoded. Any write that does not match the expected cycle sends the decoder back to read mode without starting anything.
- R3: The code 0xA0 as the third write, followed by a write of address and data, programs that word. The plane stays busy for PROG_CYCLES clock edges after the data write, and then the stored word becomes old AND new.
- R4: The code 0x80, then a second unlock, then 0x30 written to any address in a sector erases that sector. The plane is busy for ERASE_CYCLES counted edges, and then every word of the sector is 0xFFFF while other sectors are unchanged.
- R5: A read from a busy plane returns a status word and not array data. Bits 15..8 and 5..0 are 0. Bit 7 is the complement of bit 7 of the word being programmed, or 0 during an erase. Bit 6 is the plane's toggle bit, which inverts after every such read.
- R6: The plane is chosen by the address MSB. A read of the plane that is not busy returns array data.
- R7: The code 0x60 written to an address locks that address's sector. A later program or erase aimed at a locked sector is dropped: `ready` stays 1 and the data is unchanged.
- R8: The code 0xB0 written to a plane with a running erase suspends that erase. The erase counter freezes and `ready` goes high. Reads of other sectors return array data. Reads of the erasing sector return the status word with bit 7 = 0, and bit 6 does not toggle.
- R9: While an erase is suspended, a program to another sector of that plane runs normally. A program to the sector being erased is dropped.
- R10: The code 0x30 as the third write resumes a suspended erase, provided no program is running in that plane. The erase continues with its remaining count.
- R11: `ready` is 0 whenever either plane has a program or an unsuspended erase in progress.
- R12: A program or erase command aimed at a plane that already has a program or a running erase is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low, sampled each clock |
| oe_n | input | 1 | Read strobe, active low, ignored while we_n is low |
| addr | input | ADDR_W | Word address, MSB selects the plane |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, one clock after the read cycle |
| ready | output | 1 | High when no plane has work in progress |

## Verification
The bench drives programs with data whose bit 7 is both 0 and 1, and reprograms a word that is already written. This separates a plain store from the AND behaviour and shows whether the polling bit is inverted. Back-to-back status reads show whether the toggle bit moves, while repeated reads of a suspended sector show that it stays still. A broken unlock, a command to a locked sector, a program into the suspended sector and a second program into a busy plane are each issued and then read back. This proves the drop at the ports. Reads of the other plane during both program and erase tell read-while-write apart from a global busy.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

   localparam logic [7:0] CODE_KEY1    = 8'hAA;
   localparam logic [7:0] CODE_KEY2    = 8'h55;
   localparam logic [7:0] CODE_PROGRAM = 8'hA0;
   localparam logic [7:0] CODE_ERASE   = 8'h80;
   localparam logic [7:0] CODE_CONFIRM = 8'h30;
   localparam logic [7:0] CODE_SUSPEND = 8'hB0;
   localparam logic [7:0] CODE_LOCK    = 8'h60;

   typedef enum logic [2:0] {
      CS_READ,
      CS_KEY1,
      CS_KEY2,
      CS_PGM_DATA,
      CS_ER_KEY0,
      CS_ER_KEY1,
      CS_ER_KEY2
   } cmd_state_e;

   typedef struct packed {
      logic prog;
      logic erase;
      logic susp;
      logic resume;
      logic lock;
   } cmd_req_t;

endpackage

// File: rtl/flashctl_cmd_dec.sv
module flashctl_cmd_dec
   import flashctl_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int KEY1_ADR = 'h555,
   parameter int KEY2_ADR = 'h2AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        code,
   output cmd_req_t          req
);

   localparam logic [ADDR_W-1:0] K1A = ADDR_W'(KEY1_ADR);
   localparam logic [ADDR_W-1:0] K2A = ADDR_W'(KEY2_ADR);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("flashctl_cmd_dec: ADDR_W must be at least 2");
      end
   endgenerate

   cmd_state_e st, st_nxt;
   logic       key1_hit, key2_hit;

   assign key1_hit = (addr == K1A) && (code == CODE_KEY1);
   assign key2_hit = (addr == K2A) && (code == CODE_KEY2);

   always_comb begin
      st_nxt = st;
      req    = '0;
      if (wr_en) begin
         st_nxt = CS_READ;
         unique case (st)
            CS_READ:     if (key1_hit) st_nxt = CS_KEY1;
            CS_KEY1:     if (key2_hit) st_nxt = CS_KEY2;
            CS_KEY2: begin
               unique case (code)
                  CODE_PROGRAM: st_nxt     = CS_PGM_DATA;
                  CODE_ERASE:   st_nxt     = CS_ER_KEY0;
                  CODE_SUSPEND: req.susp   = 1'b1;
                  CODE_CONFIRM: req.resume = 1'b1;
                  CODE_LOCK:    req.lock   = 1'b1;
                  default:      st_nxt     = CS_READ;
               endcase
            end
            CS_PGM_DATA: req.prog = 1'b1;
            CS_ER_KEY0:  if (key1_hit) st_nxt = CS_ER_KEY1;
            CS_ER_KEY1:  if (key2_hit) st_nxt = CS_ER_KEY2;
            CS_ER_KEY2:  if (code == CODE_CONFIRM) req.erase = 1'b1;
            default:     st_nxt = CS_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= CS_READ;
      else        st <= st_nxt;
   end

   // R2: at most one command issued per write
   p_one_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req));

   // R2: a mismatched second unlock cycle drops back to read mode
   p_bad_key_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st == CS_KEY1 && !key2_hit) |=> (st == CS_READ));

endmodule

// File: rtl/flashctl_plane.sv
module flashctl_plane #(
   parameter int LADDR_W      = 7,
   parameter int SECT_AW      = 4,
   parameter int DATA_W       = 16,
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_req,
   input  logic               erase_req,
   input  logic               susp_req,
   input  logic               resume_req,
   input  logic               lock_req,
   input  logic [LADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0]  cmd_data,
   input  logic               rd_en,
   input  logic [LADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]  rd_word,
   output logic               busy
);

   localparam int WORDS  = 1 << LADDR_W;
   localparam int SECT_W = LADDR_W - SECT_AW;
   localparam int NSECT  = 1 << SECT_W;
   localparam int SWORDS = 1 << SECT_AW;
   localparam int PC_W   = $clog2(PROG_CYCLES + 1);
   localparam int EC_W   = $clog2(ERASE_CYCLES + 1);

   generate
      if (PROG_CYCLES < 1) begin : g_bad_prog
         $error("flashctl_plane: PROG_CYCLES must be positive");
      end
      if (ERASE_CYCLES < 1) begin : g_bad_erase
         $error("flashctl_plane: ERASE_CYCLES must be positive");
      end
      if (SECT_AW < 1 || SECT_AW >= LADDR_W) begin : g_bad_sect
         $error("flashctl_plane: SECT_AW must lie between 1 and LADDR_W-1");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("flashctl_plane: DATA_W must be at least 8");
      end
   endgenerate

   logic [DATA_W-1:0]  mem [WORDS];
   logic [NSECT-1:0]   locked;

   logic               p_act;
   logic [PC_W-1:0]    p_cnt;
   logic [LADDR_W-1:0] p_addr;
   logic [DATA_W-1:0]  p_data;

   logic               e_act;
   logic               e_susp;
   logic [EC_W-1:0]    e_cnt;
   logic [SECT_W-1:0]  e_sect;

   logic               tog;

   logic [SECT_W-1:0]  cmd_sect, rd_sect, p_sect;
   logic               prog_ok, erase_ok, susp_ok, resume_ok;
   logic [DATA_W-1:0]  status;

   assign cmd_sect = cmd_addr[LADDR_W-1:SECT_AW];
   assign rd_sect  = rd_addr[LADDR_W-1:SECT_AW];
   assign p_sect   = p_addr[LADDR_W-1:SECT_AW];

   assign busy = p_act | (e_act & ~e_susp);

   always_comb begin
      prog_ok   = prog_req && !p_act && !locked[cmd_sect] &&
                  (!e_act || (e_susp && cmd_sect != e_sect));
      erase_ok  = erase_req && !p_act && !e_act && !locked[cmd_sect];
      susp_ok   = susp_req && e_act && !e_susp;
      resume_ok = resume_req && e_act && e_susp && !p_act;
   end

   always_comb begin
      status    = '0;
      status[7] = p_act ? ~p_data[7] : 1'b0;
      status[6] = tog;
      if (busy)
         rd_word = status;
      else if (e_act && e_susp && rd_sect == e_sect)
         rd_word = status;
      else
         rd_word = mem[rd_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '1;
         locked <= '0;
         p_act  <= 1'b0;
         p_cnt  <= '0;
         p_addr <= '0;
         p_data <= '0;
         e_act  <= 1'b0;
         e_susp <= 1'b0;
         e_cnt  <= '0;
         e_sect <= '0;
         tog    <= 1'b0;
      end else begin
         if (rd_en && busy) tog <= ~tog;
         if (lock_req) locked[cmd_sect] <= 1'b1;

         // word program engine
         if (p_act) begin
            if (p_cnt == '0) begin
               p_act        <= 1'b0;
               mem[p_addr]  <= mem[p_addr] & p_data;
            end else begin
               p_cnt <= p_cnt - 1'b1;
            end
         end
         if (prog_ok) begin
            p_act  <= 1'b1;
            p_cnt  <= PC_W'(PROG_CYCLES - 1);
            p_addr <= cmd_addr;
            p_data <= cmd_data;
         end

         // sector erase engine
         if (susp_ok)   e_susp <= 1'b1;
         if (resume_ok) e_susp <= 1'b0;
         if (e_act && !e_susp) begin
            if (e_cnt == '0) begin
               e_act  <= 1'b0;
               e_susp <= 1'b0;
               for (int i = 0; i < SWORDS; i++)
                  mem[{e_sect, SECT_AW'(i)}] <= '1;
            end else begin
               e_cnt <= e_cnt - 1'b1;
            end
         end
         if (erase_ok) begin
            e_act  <= 1'b1;
            e_cnt  <= EC_W'(ERASE_CYCLES - 1);
            e_sect <= cmd_sect;
         end
      end
   end

   // R3: a program starts only in answer to a program request
   p_prog_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(p_act) |-> $past(prog_req));

   // R7: a program aimed at a locked sector never starts
   p_locked_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && locked[cmd_sect] && !p_act) |=> !p_act);

   // R7: an erase aimed at a locked sector never starts
   p_locked_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && locked[cmd_sect] && !e_act) |=> !e_act);

   // R8: the erase count is frozen while suspended
   p_susp_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (e_act && e_susp && $past(e_act && e_susp)) |-> $stable(e_cnt));

   // R9: a program never runs inside the sector under erase
   p_prog_outside_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (p_act && e_act) |-> (p_sect != e_sect));

   // R5: each status read of a busy plane inverts the toggle bit
   p_toggle_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (tog != $past(tog)));

endmodule

// File: rtl/flashctl_dualplane.sv
module flashctl_dualplane
   import flashctl_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int SECT_AW      = 4,
   parameter int DATA_W       = 16,
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 256,
   parameter int KEY1_ADR     = 'h555,
   parameter int KEY2_ADR     = 'h2AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready
);

   localparam int NPLANES = 2;
   localparam int LADDR_W = ADDR_W - 1;

   generate
      if (SECT_AW >= LADDR_W) begin : g_bad_split
         $error("flashctl_dualplane: a plane must hold at least two sectors");
      end
   endgenerate

   logic              wr_en, rd_en;
   logic              plane_sel;
   cmd_req_t          req;
   logic [DATA_W-1:0] rd_word [NPLANES];
   logic [NPLANES-1:0] busy;

   assign wr_en     = !ce_n && !we_n;
   assign rd_en     = !ce_n && !oe_n && we_n;
   assign plane_sel = addr[ADDR_W-1];

   flashctl_cmd_dec #(
      .ADDR_W  (ADDR_W),
      .KEY1_ADR(KEY1_ADR),
      .KEY2_ADR(KEY2_ADR)
   ) cmd_dec_i (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .addr (addr),
      .code (wdata[7:0]),
      .req  (req)
   );

   generate
      for (genvar p = 0; p < NPLANES; p++) begin : g_plane
         logic hit;
         assign hit = (plane_sel == 1'(p));

         flashctl_plane #(
            .LADDR_W     (LADDR_W),
            .SECT_AW     (SECT_AW),
            .DATA_W      (DATA_W),
            .PROG_CYCLES (PROG_CYCLES),
            .ERASE_CYCLES(ERASE_CYCLES)
         ) plane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog_req  (req.prog   && hit),
            .erase_req (req.erase  && hit),
            .susp_req  (req.susp   && hit),
            .resume_req(req.resume && hit),
            .lock_req  (req.lock   && hit),
            .cmd_addr  (addr[LADDR_W-1:0]),
            .cmd_data  (wdata),
            .rd_en     (rd_en && hit),
            .rd_addr   (addr[LADDR_W-1:0]),
            .rd_word   (rd_word[p]),
            .busy      (busy[p])
         );
      end
   endgenerate

   assign ready = ~|busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word[plane_sel];
   end

   // R6: a read of the idle plane while the other one works updates rdata with array data
   p_idle_plane_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !busy[plane_sel]) |=> (rdata == $past(rd_word[plane_sel])));

endmodule

// File: tb/flashctl_dualplane_tb_top.sv
`timescale 1ns/1ps
module flashctl_dualplane_tb_top;

   localparam int PROGN  = 16;
   localparam int ERASEN = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        ready;

   always #2 clk = ~clk;

   flashctl_dualplane dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
   );

   int    nvec = 0;
   int    nfail = 0;
   string tag = "R1";
   bit    done = 1'b0;

   task automatic chk(input string rq, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [15:0] m_mem [256];
   bit          m_lock [16];
   int          pleft [2], eleft [2], esect [2];
   logic [7:0]  paddr [2];
   logic [15:0] pdata [2];
   bit          esusp [2], tgl [2];
   int          cst;
   logic [15:0] m_rdata;

   function automatic bit m_busy(input int q);
      return pleft[q] > 0 || (eleft[q] > 0 && !esusp[q]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
         foreach (m_lock[i]) m_lock[i] = 0;
         for (int q = 0; q < 2; q++) begin
            pleft[q] = 0; eleft[q] = 0; esect[q] = 0; esusp[q] = 0; tgl[q] = 0;
            paddr[q] = 0; pdata[q] = 0;
         end
         cst = 0;
         m_rdata = 0;
      end else begin
         automatic bit wr = !ce_n && !we_n;
         automatic bit rd = !ce_n && !oe_n && we_n;
         automatic int p = addr[7];
         automatic int sec = addr[7:4];
         automatic logic [7:0] c = wdata[7:0];
         automatic string kind = "";
         automatic bit okp, oke, oks, okr;
         automatic bit edone [2] = '{0, 0};
         if (rd) begin
            automatic bit poll = (pleft[p] > 0) ? ~pdata[p][7] : 1'b0;
            if (m_busy(p)) begin
               m_rdata = {8'h00, poll, tgl[p], 6'h00};
               tgl[p] = ~tgl[p];
            end else if (eleft[p] > 0 && esusp[p] && sec == esect[p])
               m_rdata = {8'h00, poll, tgl[p], 6'h00};
            else
               m_rdata = m_mem[addr];
         end
         if (wr) begin
            case (cst)
               0: cst = (addr == 8'h55 && c == 8'hAA) ? 1 : 0;
               1: cst = (addr == 8'hAA && c == 8'h55) ? 2 : 0;
               2: begin
                  cst = 0;
                  if (c == 8'hA0) cst = 3;
                  else if (c == 8'h80) cst = 4;
                  else if (c == 8'hB0) kind = "susp";
                  else if (c == 8'h30) kind = "res";
                  else if (c == 8'h60) kind = "lock";
               end
               3: begin kind = "prog"; cst = 0; end
               4: cst = (addr == 8'h55 && c == 8'hAA) ? 5 : 0;
               5: cst = (addr == 8'hAA && c == 8'h55) ? 6 : 0;
               6: begin if (c == 8'h30) kind = "erase"; cst = 0; end
               default: cst = 0;
            endcase
         end
         okp = kind == "prog" && pleft[p] == 0 && !m_lock[sec] &&
               (eleft[p] == 0 || (esusp[p] && sec != esect[p]));
         oke = kind == "erase" && pleft[p] == 0 && eleft[p] == 0 && !m_lock[sec];
         oks = kind == "susp" && eleft[p] > 0 && !esusp[p];
         okr = kind == "res" && eleft[p] > 0 && esusp[p] && pleft[p] == 0;
         for (int q = 0; q < 2; q++) begin
            if (pleft[q] > 0) begin
               pleft[q]--;
               if (pleft[q] == 0) m_mem[paddr[q]] = m_mem[paddr[q]] & pdata[q];
            end
            if (eleft[q] > 0 && !esusp[q]) begin
               eleft[q]--;
               if (eleft[q] == 0) begin
                  for (int w = 0; w < 16; w++) m_mem[esect[q]*16 + w] = 16'hFFFF;
                  edone[q] = 1;
               end
            end
         end
         if (kind == "lock") m_lock[sec] = 1;
         if (okp) begin pleft[p] = PROGN; paddr[p] = addr; pdata[p] = wdata; end
         if (oke) begin eleft[p] = ERASEN; esect[p] = sec; end
         if (oks) esusp[p] = 1;
         if (okr) esusp[p] = 0;
         for (int q = 0; q < 2; q++) if (edone[q]) esusp[q] = 0;
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tag, "ready", {15'h0, ready}, {15'h0, !(m_busy(0) || m_busy(1))});
         chk(tag, "rdata", rdata, m_rdata);
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
      ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
      @(negedge clk);
      ce_n = 1; we_n = 1;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [15:0] v);
      ce_n = 0; oe_n = 0; we_n = 1; addr = a;
      @(negedge clk);
      v = rdata;
      ce_n = 1; oe_n = 1;
   endtask

   task automatic unlock();
      bus_wr(8'h55, 16'h00AA);
      bus_wr(8'hAA, 16'h0055);
   endtask

   task automatic program_word(input logic [7:0] a, input logic [15:0] d);
      unlock();
      bus_wr(8'h55, 16'h00A0);
      bus_wr(a, d);
   endtask

   task automatic erase_sector(input logic [7:0] a);
      unlock();
      bus_wr(8'h55, 16'h0080);
      unlock();
      bus_wr(a, 16'h0030);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired in phase %s", tag);
      finish_run();
   end

   initial begin
      logic [15:0] v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      tag = "R1";
      chk("R1", "ready after reset", {15'h0, ready}, 16'h0001);
      chk("R1", "rdata after reset", rdata, 16'h0000);
      bus_rd(8'h10, v);
      chk("R1", "erased word", v, 16'hFFFF);

      tag = "R2";
      bus_wr(8'h55, 16'h00AA);
      bus_wr(8'hAA, 16'h0056);
      bus_wr(8'h55, 16'h00A0);
      bus_wr(8'h12, 16'h0000);
      idle(2);
      chk("R2", "ready after broken unlock", {15'h0, ready}, 16'h0001);
      idle(20);
      bus_rd(8'h12, v);
      chk("R2", "word untouched by broken sequence", v, 16'hFFFF);

      tag = "R3";
      program_word(8'h12, 16'h1234);
      chk("R11", "ready low while programming", {15'h0, ready}, 16'h0000);
      bus_rd(8'h12, v);
      chk("R5", "first status read", v, 16'h0080);
      bus_rd(8'h12, v);
      chk("R5", "second status read toggles", v, 16'h00C0);
      bus_rd(8'h90, v);
      chk("R6", "other plane during program", v, 16'hFFFF);
      idle(20);
      bus_rd(8'h12, v);
      chk("R3", "programmed word", v, 16'h1234);
      program_word(8'h12, 16'hFF0F);
      idle(20);
      bus_rd(8'h12, v);
      chk("R3", "reprogram ANDs bits", v, 16'h1204);
      program_word(8'h13, 16'h0080);
      bus_rd(8'h13, v);
      chk("R5", "poll bit for data bit7=1", v & 16'hFF80, 16'h0000);
      idle(20);

      tag = "R8";
      erase_sector(8'h15);
      idle(40);
      bus_rd(8'h12, v);
      chk("R5", "erase status high bits and poll", v & 16'hFF80, 16'h0000);
      bus_rd(8'h90, v);
      chk("R6", "other plane during erase", v, 16'hFFFF);
      unlock();
      bus_wr(8'h10, 16'h00B0);
      idle(3);
      chk("R8", "ready high while suspended", {15'h0, ready}, 16'h0001);
      bus_rd(8'h12, v);
      bus_rd(8'h12, v2);
      chk("R8", "suspended sector status holds", v2, v);
      chk("R8", "suspended sector poll bit", v & 16'hFF80, 16'h0000);
      bus_rd(8'h30, v);
      chk("R8", "other sector while suspended", v, 16'hFFFF);

      tag = "R9";
      program_word(8'h31, 16'h00FF);
      chk("R9", "program during suspend runs", {15'h0, ready}, 16'h0000);
      idle(20);
      bus_rd(8'h31, v);
      chk("R9", "program during suspend result", v, 16'h00FF);
      program_word(8'h15, 16'h0000);
      idle(2);
      chk("R9", "program into erasing sector dropped", {15'h0, ready}, 16'h0001);

      tag = "R10";
      unlock();
      bus_wr(8'h10, 16'h0030);
      idle(100);
      chk("R10", "erase still running after resume", {15'h0, ready}, 16'h0000);
      idle(200);
      chk("R10", "erase finished", {15'h0, ready}, 16'h0001);
      tag = "R4";
      bus_rd(8'h12, v);
      chk("R4", "erased word 0x12", v, 16'hFFFF);
      bus_rd(8'h15, v);
      chk("R4", "word 0x15 kept erased", v, 16'hFFFF);
      bus_rd(8'h31, v);
      chk("R4", "neighbour sector unchanged", v, 16'h00FF);

      tag = "R7";
      program_word(8'h22, 16'h5555);
      idle(20);
      unlock();
      bus_wr(8'h20, 16'h0060);
      program_word(8'h21, 16'h0000);
      chk("R7", "program to locked sector dropped", {15'h0, ready}, 16'h0001);
      erase_sector(8'h20);
      chk("R7", "erase of locked sector dropped", {15'h0, ready}, 16'h0001);
      idle(5);
      bus_rd(8'h21, v);
      chk("R7", "locked word unchanged", v, 16'hFFFF);
      bus_rd(8'h22, v);
      chk("R7", "locked data survives erase", v, 16'h5555);

      tag = "R12";
      program_word(8'h40, 16'h0F0F);
      program_word(8'h80, 16'hAAAA);
      chk("R11", "ready low with both planes busy", {15'h0, ready}, 16'h0000);
      program_word(8'h41, 16'h0000);
      erase_sector(8'h45);
      idle(30);
      chk("R12", "all work done", {15'h0, ready}, 16'h0001);
      bus_rd(8'h41, v);
      chk("R12", "program to busy plane dropped", v, 16'hFFFF);
      bus_rd(8'h45, v);
      chk("R12", "erase to busy plane dropped", v, 16'hFFFF);
      bus_rd(8'h40, v);
      chk("R3", "plane A word", v, 16'h0F0F);
      bus_rd(8'h80, v);
      chk("R6", "plane B word", v, 16'hAAAA);

      idle(2);
      finish_run();
   end

endmodule